// File: doc/BRIEF.md
# NAND Page Access Sequencer

This block runs page reads, page programs and block erases on one asynchronous 8-bit NAND flash channel. A controller raises a request that carries an operation code, a row address and a column address. The block then drives chip enable, the two latch enables, the write and read strobes and the data bus through each command, address and data cycle. It waits out the array-busy phase on the ready/busy line. Each wait is bounded by a cycle count that is set per operation.

A read streams the whole page back to the controller, one byte per `rd_valid` pulse. A program pulls the page from the controller, one byte per `wr_take` pulse. It closes with a confirm command. Program and erase both end with a status poll, and bit 0 of the status byte becomes the fail flag. Every operation ends with a one-clock `done` pulse. The pulse carries the `fail` and `timed_out` flags.

Top module: `nand_page_seq`

## Requirements
- R1: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high. `nand_cle`, `nand_ale`, `nand_dq_oe`, `busy` and `done` are low.
- R2: A read (`req_op` = 0) issues seven write cycles in this order: command 00h, then two column bytes least significant first, then three row bytes least significant first, then command 30h.
- R3: After the read confirm, once ready/busy is high, the block makes exactly DATA_BYTES+SPARE_BYTES read cycles (4320 by default). Each byte appears on `rd_data` with a one-clock `rd_valid`, in bus order.
- R4: A program (`req_op` = 1) issues command 80h, then the five address bytes as in R2, then DATA_BYTES+SPARE_BYTES data cycles taken from `wr_data` in order, then command 10h.
- R5: An erase (`req_op` = 2) issues command 60h, then the three row bytes least significant first, then command D0h. No column bytes are sent.
- R6: After the program or erase busy phase, the block issues command 70h and one read cycle. `fail` equals bit 0 of that status byte.
- R7: If ready/busy stays low past the operation's wait limit, the operation ends with `timed_out` high and `fail` low. No data or status cycles follow.
- R8: Each write or read strobe is low for one clock and then high for at least one clock. CLE and ALE are high only during command and address cycles respectively, and never together. Chip enable is low exactly while `busy` is high.
- R9: A request is taken only when `busy` is low and `req_op` is not 3. A request made while busy, or with code 3, causes no bus cycle.
- R10: `done` is a one-clock pulse, issued in the cycle `busy` falls. `fail` and `timed_out` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| req_row | input | 8*ROW_BYTES | Page/block row address |
| req_col | input | 8*COL_BYTES | Column address |
| busy | output | 1 | Operation in progress |
| wr_data | input | 8 | Program data byte |
| wr_take | output | 1 | Pulses the clock after a `wr_data` byte is consumed |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | `rd_data` valid |
| done | output | 1 | Operation complete pulse |
| fail | output | 1 | Status fail bit |
| timed_out | output | 1 | Busy wait expired |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus data driven to flash |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus data from flash |
| nand_rb | input | 1 | Ready (high) / busy (low) |

## Verification
Completion of one operation and acceptance of the next can fall in the same cycle, because `done` is raised in the cycle the block returns to idle. The bench provokes this by holding a second read request asserted while a first read is still streaming. It then checks three things at the done pulse:
- the first result flags are correct;
- `busy` is high again in the very next clock;
- the scoreboard sees the second command and address sequence directly after the first page, with no lost or duplicated bus cycle.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } nand_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMD1,
    S_ADDR,
    S_WDATA,
    S_CMD2,
    S_WAIT,
    S_SCMD,
    S_SRD,
    S_RDATA
  } seq_state_e;

  localparam logic [7:0] CMD_RD_SETUP = 8'h00;
  localparam logic [7:0] CMD_RD_GO    = 8'h30;
  localparam logic [7:0] CMD_PG_SETUP = 8'h80;
  localparam logic [7:0] CMD_PG_GO    = 8'h10;
  localparam logic [7:0] CMD_ER_SETUP = 8'h60;
  localparam logic [7:0] CMD_ER_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;

endpackage

// File: rtl/nand_addr_pick.sv
module nand_addr_pick #(
  parameter int COL_BYTES = 2,
  parameter int ROW_BYTES = 3,
  parameter int IDX_W     = $clog2(COL_BYTES + ROW_BYTES)
) (
  input  logic [8*COL_BYTES-1:0] col,
  input  logic [8*ROW_BYTES-1:0] row,
  input  logic [IDX_W-1:0]       idx,
  output logic [7:0]             byte_o
);
  localparam int NB = COL_BYTES + ROW_BYTES;

  logic [8*NB-1:0] flat;
  assign flat = {row, col};

  // Byte index 0 is the lowest column byte; row bytes follow the column bytes.
  always_comb begin
    byte_o = '0;
    for (int i = 0; i < NB; i++) begin
      if (idx == IDX_W'(i)) byte_o = flat[8*i +: 8];
    end
  end
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int TW    = 16,
  parameter int GUARD = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] limit,
  input  logic          rb,
  output logic          fin,
  output logic          expired
);
  logic          run;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      cnt     <= '0;
      fin     <= 1'b0;
      expired <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        run     <= 1'b1;
        cnt     <= '0;
        expired <= 1'b0;
      end else if (run) begin
        // Ready/busy is not trusted until the flash has had time to pull it low.
        if (cnt >= TW'(GUARD) && rb) begin
          fin <= 1'b1;
          run <= 1'b0;
        end else if (cnt >= limit) begin
          fin     <= 1'b1;
          expired <= 1'b1;
          run     <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7: a wait that is still busy at its limit ends as expired on the next clock
  p_expire_at_limit_r7: assert property (@(posedge clk) disable iff (rst)
    (run && !start && !rb && cnt >= limit) |=> (fin && expired));

  // R7: a finish is only reported for a wait that was running
  p_fin_from_run_r7: assert property (@(posedge clk) disable iff (rst)
    fin |-> $past(run));
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_BYTES    = 4096,
  parameter int SPARE_BYTES   = 224,
  parameter int COL_BYTES     = 2,
  parameter int ROW_BYTES     = 3,
  parameter int RD_WAIT_CLKS  = 1250,
  parameter int PG_WAIT_CLKS  = 10000,
  parameter int ER_WAIT_CLKS  = 35000,
  parameter int RB_GUARD_CLKS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [1:0]             req_op,
  input  logic [8*ROW_BYTES-1:0] req_row,
  input  logic [8*COL_BYTES-1:0] req_col,
  output logic                   busy,
  input  logic [7:0]             wr_data,
  output logic                   wr_take,
  output logic [7:0]             rd_data,
  output logic                   rd_valid,
  output logic                   done,
  output logic                   fail,
  output logic                   timed_out,
  output logic                   nand_ce_n,
  output logic                   nand_cle,
  output logic                   nand_ale,
  output logic                   nand_we_n,
  output logic                   nand_re_n,
  output logic [7:0]             nand_dq_out,
  output logic                   nand_dq_oe,
  input  logic [7:0]             nand_dq_in,
  input  logic                   nand_rb
);
  localparam int PAGE_BYTES = DATA_BYTES + SPARE_BYTES;
  localparam int ADDR_BYTES = COL_BYTES + ROW_BYTES;
  localparam int CNT_W      = $clog2(PAGE_BYTES + 1);
  localparam int AIDX_W     = $clog2(ADDR_BYTES);
  localparam int WAIT_MAX   = (ER_WAIT_CLKS > PG_WAIT_CLKS) ?
                              ((ER_WAIT_CLKS > RD_WAIT_CLKS) ? ER_WAIT_CLKS : RD_WAIT_CLKS) :
                              ((PG_WAIT_CLKS > RD_WAIT_CLKS) ? PG_WAIT_CLKS : RD_WAIT_CLKS);
  localparam int TMR_W      = $clog2(WAIT_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(PAGE_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] FIRST_ROW = CNT_W'(COL_BYTES);

  seq_state_e             state;
  logic                   ph;
  nand_op_e               op;
  logic [8*ROW_BYTES-1:0] row_q;
  logic [8*COL_BYTES-1:0] col_q;
  logic [CNT_W-1:0]       cnt;
  logic                   tmr_start, tmr_fin, tmr_exp;
  logic [TMR_W-1:0]       tmr_limit;
  logic [7:0]             addr_byte, wbyte;

  nand_addr_pick #(
    .COL_BYTES(COL_BYTES),
    .ROW_BYTES(ROW_BYTES),
    .IDX_W    (AIDX_W)
  ) u_addr (
    .col   (col_q),
    .row   (row_q),
    .idx   (cnt[AIDX_W-1:0]),
    .byte_o(addr_byte)
  );

  nand_busy_timer #(
    .TW   (TMR_W),
    .GUARD(RB_GUARD_CLKS)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (tmr_start),
    .limit  (tmr_limit),
    .rb     (nand_rb),
    .fin    (tmr_fin),
    .expired(tmr_exp)
  );

  always_comb begin
    case (op)
      OP_READ: tmr_limit = TMR_W'(RD_WAIT_CLKS);
      OP_PROG: tmr_limit = TMR_W'(PG_WAIT_CLKS);
      default: tmr_limit = TMR_W'(ER_WAIT_CLKS);
    endcase
    case (state)
      S_CMD1:  wbyte = (op == OP_READ) ? CMD_RD_SETUP :
                       (op == OP_PROG) ? CMD_PG_SETUP : CMD_ER_SETUP;
      S_ADDR:  wbyte = addr_byte;
      S_WDATA: wbyte = wr_data;
      S_CMD2:  wbyte = (op == OP_READ) ? CMD_RD_GO :
                       (op == OP_PROG) ? CMD_PG_GO : CMD_ER_GO;
      S_SCMD:  wbyte = CMD_STATUS;
      default: wbyte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      ph          <= 1'b0;
      op          <= OP_READ;
      row_q       <= '0;
      col_q       <= '0;
      cnt         <= '0;
      tmr_start   <= 1'b0;
      busy        <= 1'b0;
      wr_take     <= 1'b0;
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      done        <= 1'b0;
      fail        <= 1'b0;
      timed_out   <= 1'b0;
      nand_ce_n   <= 1'b1;
      nand_cle    <= 1'b0;
      nand_ale    <= 1'b0;
      nand_we_n   <= 1'b1;
      nand_re_n   <= 1'b1;
      nand_dq_out <= '0;
      nand_dq_oe  <= 1'b0;
    end else begin
      done      <= 1'b0;
      rd_valid  <= 1'b0;
      wr_take   <= 1'b0;
      tmr_start <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid && req_op != 2'b11) begin
            op        <= nand_op_e'(req_op);
            row_q     <= req_row;
            col_q     <= req_col;
            busy      <= 1'b1;
            nand_ce_n <= 1'b0;
            fail      <= 1'b0;
            timed_out <= 1'b0;
            ph        <= 1'b0;
            state     <= S_CMD1;
          end
        end
        S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_SCMD: begin
          if (!ph) begin
            ph          <= 1'b1;
            nand_we_n   <= 1'b0;
            nand_dq_oe  <= 1'b1;
            nand_dq_out <= wbyte;
            nand_cle    <= (state == S_CMD1) || (state == S_CMD2) || (state == S_SCMD);
            nand_ale    <= (state == S_ADDR);
            wr_take     <= (state == S_WDATA);
          end else begin
            ph        <= 1'b0;
            nand_we_n <= 1'b1;
            case (state)
              S_CMD1: begin
                state <= S_ADDR;
                cnt   <= (op == OP_ERASE) ? FIRST_ROW : '0;
              end
              S_ADDR: begin
                if (cnt == LAST_ADDR) begin
                  cnt   <= '0;
                  state <= (op == OP_PROG) ? S_WDATA : S_CMD2;
                end else cnt <= cnt + 1'b1;
              end
              S_WDATA: begin
                if (cnt == LAST_DATA) begin
                  cnt   <= '0;
                  state <= S_CMD2;
                end else cnt <= cnt + 1'b1;
              end
              S_CMD2: begin
                state     <= S_WAIT;
                tmr_start <= 1'b1;
              end
              default: state <= S_SRD;
            endcase
          end
        end
        S_WAIT: begin
          nand_cle   <= 1'b0;
          nand_ale   <= 1'b0;
          nand_dq_oe <= 1'b0;
          if (tmr_fin) begin
            if (tmr_exp) begin
              timed_out <= 1'b1;
              state     <= S_IDLE;
              busy      <= 1'b0;
              done      <= 1'b1;
              nand_ce_n <= 1'b1;
            end else if (op == OP_READ) begin
              state <= S_RDATA;
              cnt   <= '0;
            end else begin
              state <= S_SCMD;
            end
          end
        end
        S_RDATA, S_SRD: begin
          nand_cle   <= 1'b0;
          nand_ale   <= 1'b0;
          nand_dq_oe <= 1'b0;
          if (!ph) begin
            ph        <= 1'b1;
            nand_re_n <= 1'b0;
          end else begin
            ph        <= 1'b0;
            nand_re_n <= 1'b1;
            if (state == S_SRD) begin
              fail      <= nand_dq_in[0];
              state     <= S_IDLE;
              busy      <= 1'b0;
              done      <= 1'b1;
              nand_ce_n <= 1'b1;
            end else begin
              rd_data  <= nand_dq_in;
              rd_valid <= 1'b1;
              if (cnt == LAST_DATA) begin
                state     <= S_IDLE;
                busy      <= 1'b0;
                done      <= 1'b1;
                nand_ce_n <= 1'b1;
              end else cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: latch enables are mutually exclusive
  p_cle_ale_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));
  // R8: never strobe write and read together
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));
  // R8: write strobe low for a single clock
  p_we_one_low_r8: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |=> nand_we_n);
  // R8: read strobe low for a single clock
  p_re_one_low_r8: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |=> nand_re_n);
  // R8: strobes only with the chip selected
  p_ce_on_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  // R9: a valid request in idle starts an operation
  p_accept_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && req_op != 2'b11) |=> busy);
  // R10: done is a single-clock pulse and coincides with idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R3: data counter never passes the page length
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_RDATA || state == S_WDATA) |-> cnt <= LAST_DATA);
  // R7: a timeout flag only appears with done
  p_tmo_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(timed_out) |-> done);
endmodule

// File: tb/test_nand_page_seq.sv
module test_nand_page_seq;
  localparam int PAGE = 4096 + 224;
  localparam int T_RD = 100;
  localparam int T_PG = 300;
  localparam int T_ER = 500;

  logic        clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [23:0] req_row;
  logic [15:0] req_col;
  logic        busy, wr_take, rd_valid, done, fail, timed_out;
  logic [7:0]  wr_data, rd_data;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out, nand_dq_in;
  logic        nand_rb;

  nand_page_seq i_nand_page_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_row(req_row), .req_col(req_col), .busy(busy),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .fail(fail), .timed_out(timed_out),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  int vectors = 0;
  int errors  = 0;
  int viol    = 0;

  logic [9:0] exp_bus[$];
  string      exp_tag[$];
  logic [7:0] exp_rd[$];

  function automatic logic [7:0] page_pat(int i, logic [7:0] s);
    return 8'(i * 13) ^ s;
  endfunction
  function automatic logic [7:0] wr_pat(int i);
    return 8'(i * 5 + 3) ^ 8'hA5;
  endfunction

  // flash model and monitors, all on the falling edge
  logic       we_q = 1'b1, re_q = 1'b1;
  int         busy_cnt = 0;
  bit         hang = 0;
  bit         stat_mode = 0;
  bit         fail_inj = 0;
  int         ridx = 0;
  int         wr_idx = 0;
  logic [7:0] seed = 8'h00;

  assign nand_rb    = (busy_cnt == 0) && !hang;
  assign nand_dq_in = stat_mode ? {7'b0, fail_inj} : page_pat(ridx, seed);
  assign wr_data    = wr_pat(wr_idx);

  always @(negedge clk) begin
    we_q <= nand_we_n;
    re_q <= nand_re_n;
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (!rst) begin
      if (wr_take) wr_idx <= wr_idx + 1;
      if (nand_re_n && !re_q) ridx <= ridx + 1;
      // R8 pin discipline
      if (nand_cle && nand_ale) viol++;
      if (!nand_we_n && !we_q) viol++;
      if (!nand_re_n && !re_q) viol++;
      if (nand_ce_n != !busy) viol++;
      if (nand_we_n && !we_q) begin
        vectors++;
        if (exp_bus.size() == 0) begin
          errors++;
          $display("FAIL R9: unexpected bus cycle cle=%0b ale=%0b dq=%0h, expected none",
                   nand_cle, nand_ale, nand_dq_out);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_bus.pop_front();
          t = exp_tag.pop_front();
          if (e != {nand_cle, nand_ale, nand_dq_out}) begin
            errors++;
            $display("FAIL %s: bus cycle got %0h expected %0h", t,
                     {nand_cle, nand_ale, nand_dq_out}, e);
          end
        end
        if (nand_cle) begin
          case (nand_dq_out)
            8'h00: begin stat_mode <= 0; ridx <= 0; end
            8'h30: busy_cnt <= T_RD;
            8'h10: busy_cnt <= T_PG;
            8'hD0: busy_cnt <= T_ER;
            8'h70: stat_mode <= 1;
            default: ;
          endcase
        end
      end
      if (rd_valid) begin
        vectors++;
        if (exp_rd.size() == 0) begin
          errors++;
          $display("FAIL R7: rd_data %0h delivered, expected no data", rd_data);
        end else begin
          logic [7:0] x;
          x = exp_rd.pop_front();
          if (x != rd_data) begin
            errors++;
            $display("FAIL R3: rd_data got %0h expected %0h", rd_data, x);
          end
        end
      end
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push_bus(logic c, logic a, logic [7:0] b, string tag);
    exp_bus.push_back({c, a, b});
    exp_tag.push_back(tag);
  endtask

  // driver: queue every expected bus cycle and read byte for one operation
  task automatic expect_op(logic [1:0] op, logic [15:0] col, logic [23:0] row, bit stuck);
    string t;
    t = (op == 2'd0) ? "R2" : (op == 2'd1) ? "R4" : "R5";
    push_bus(1, 0, (op == 2'd0) ? 8'h00 : (op == 2'd1) ? 8'h80 : 8'h60, t);
    if (op != 2'd2) begin
      push_bus(0, 1, col[7:0], t);
      push_bus(0, 1, col[15:8], t);
    end
    push_bus(0, 1, row[7:0], t);
    push_bus(0, 1, row[15:8], t);
    push_bus(0, 1, row[23:16], t);
    if (op == 2'd1)
      for (int i = 0; i < PAGE; i++) push_bus(0, 0, wr_pat(wr_idx + i), "R4");
    push_bus(1, 0, (op == 2'd0) ? 8'h30 : (op == 2'd1) ? 8'h10 : 8'hD0, t);
    if (!stuck) begin
      if (op == 2'd0) for (int i = 0; i < PAGE; i++) exp_rd.push_back(page_pat(i, seed));
      else push_bus(1, 0, 8'h70, "R6");
    end
  endtask

  task automatic issue(logic [1:0] op, logic [15:0] col, logic [23:0] row);
    @(negedge clk);
    req_valid = 1; req_op = op; req_col = col; req_row = row;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic finish_checks(bit exp_fail, bit exp_tmo);
    check(fail == exp_fail, "R6", "fail at done", fail, exp_fail);
    check(timed_out == exp_tmo, "R7", "timed_out at done", timed_out, exp_tmo);
    check(busy == 0, "R10", "busy at done", busy, 0);
    @(negedge clk);
    check(done == 0, "R10", "done one clock later", done, 0);
  endtask

  task automatic run_op(logic [1:0] op, logic [15:0] col, logic [23:0] row,
                        bit exp_fail, bit exp_tmo);
    expect_op(op, col, row, exp_tmo);
    issue(op, col, row);
    check(busy == 1, "R9", "busy after request", busy, 1);
    wait_done();
    finish_checks(exp_fail, exp_tmo);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst = 1; req_valid = 0; req_op = 0; req_row = 0; req_col = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(nand_ce_n && nand_we_n && nand_re_n, "R1", "strobes/ce high", {nand_ce_n, nand_we_n, nand_re_n}, 7);
    check(!nand_cle && !nand_ale && !nand_dq_oe, "R1", "cle/ale/oe low", {nand_cle, nand_ale, nand_dq_oe}, 0);
    check(!busy && !done, "R1", "busy/done low", {busy, done}, 0);

    // R9 reserved op code is ignored
    issue(2'b11, 16'h1234, 24'h56789A);
    check(busy == 0, "R9", "busy after op 3", busy, 0);
    repeat (5) @(negedge clk);
    check(exp_bus.size() == 0, "R9", "pending bus cycles", exp_bus.size(), 0);

    // R2 R3 page read
    seed = 8'h3C;
    run_op(2'd0, 16'h10A7, 24'h01027F, 0, 0);

    // R4 R6 program, and R9 a request during the operation is ignored
    expect_op(2'd1, 16'h0000, 24'hABCDEF, 0);
    issue(2'd1, 16'h0000, 24'hABCDEF);
    repeat (40) @(negedge clk);
    req_valid = 1; req_op = 2'd2; req_row = 24'h111111;
    @(negedge clk);
    req_valid = 0;
    check(busy == 1, "R9", "busy during program", busy, 1);
    wait_done();
    finish_checks(0, 0);

    // R5 R6 erase with status fail bit set
    fail_inj = 1;
    run_op(2'd2, 16'hFFFF, 24'h000380, 1, 0);

    // R6 program with status fail bit set
    run_op(2'd1, 16'h0800, 24'h000381, 1, 0);
    fail_inj = 0;

    // R7 ready/busy stuck low: read ends on timeout
    hang = 1;
    run_op(2'd0, 16'h0002, 24'h0C0000, 0, 1);
    repeat (20) @(negedge clk);
    check(exp_bus.size() == 0 && exp_rd.size() == 0, "R7", "leftover expectations",
          exp_bus.size() + exp_rd.size(), 0);
    hang = 0;

    // R10 R9 completion and a held request fall in the same cycle
    seed = 8'h81;
    expect_op(2'd0, 16'h0001, 24'h000200, 0);
    issue(2'd0, 16'h0001, 24'h000200);
    expect_op(2'd0, 16'h0003, 24'h000201, 0);
    req_valid = 1; req_op = 2'd0; req_col = 16'h0003; req_row = 24'h000201;
    wait_done();
    check(fail == 0 && timed_out == 0, "R10", "first result flags", {fail, timed_out}, 0);
    @(negedge clk);
    check(busy == 1, "R10", "busy right after done", busy, 1);
    req_valid = 0;
    wait_done();
    finish_checks(0, 0);

    repeat (10) @(negedge clk);
    check(exp_bus.size() == 0, "R2", "unconsumed bus expectations", exp_bus.size(), 0);
    check(exp_rd.size() == 0, "R3", "unconsumed read bytes", exp_rd.size(), 0);
    check(viol == 0, "R8", "pin discipline violations", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule